// File: doc/BRIEF.md
# Modem Handshake Control and Status with Local Loopback

This block holds the handshake state of one serial channel. A control register, written by the CPU, drives the active-low request-to-send, data-terminal-ready and auxiliary output pins. It also holds an internal-only output bit and the loopback enable. A status register reports the present levels of the four incoming handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It also holds four sticky change flags that raise an interrupt request. Reading the status register clears the change flags.

When loopback is enabled, the block cuts the channel off from the outside world for self-test. The serial transmit pin idles high. The transmit stream of the UART core is returned to the core's receive input. The handshake outputs are parked inactive. The status logic then sees the control bits in place of the external modem inputs: RTS appears as CTS, DTR as DSR, the internal bit as RI and the auxiliary bit as CD. The external modem inputs pass through a synchronizer of `SYNC_STAGES` flops before they are sampled.

Top module: `modem_ctl_loop`

## Requirements
- R1: A change of CTS, DSR or CD in either direction sets status bit 0, 1 or 3 respectively. Levels are taken as the inverse of the active-low pin.
- R2: Status bit 2 sets only when RI goes from active to inactive; RI becoming active sets no flag.
- R3: A read at `STAT_ADDR` returns, one cycle later, the levels CD, RI, DSR, CTS in bits 7..4 and the change flags in bits 3..0. The read clears the flags. A change detected in the same cycle as the read remains set.
- R4: `msi_irq` is high whenever any change flag is set and falls in the cycle after the read that clears the last one.
- R5: Control register at `CTRL_ADDR`: bit 0 DTR, bit 1 RTS, bit 2 internal bit, bit 3 auxiliary, bit 4 loopback. A 1 in bit 0, 1 or 3 drives `dtr_n`, `rts_n` or `aux_n` low in the cycle after the write. The register reads back in bits 4..0.
- R6: `txd` is high during reset and while loopback is enabled; otherwise it follows `core_txd` with one register delay.
- R7: `core_rxd` carries `core_txd` while loopback is enabled and `rxd` otherwise, with one register delay.
- R8: With loopback enabled, `rts_n`, `dtr_n` and `aux_n` are held high and the external modem inputs are ignored. The status levels are then taken from the control bits: RTS as CTS, DTR as DSR, bit 2 as RI and bit 3 as CD.
- R9: Reset clears the control register and the change flags. It sets all output pins high, `msi_irq` low and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| cd_n | input | 1 | Carrier detect pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| aux_n | output | 1 | Auxiliary output pin, active low |
| core_txd | input | 1 | Transmit serial stream from the UART core |
| core_rxd | output | 1 | Receive serial stream to the UART core |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and the default register addresses. This gives the external pin path a latency the bench cannot match by accident, so it waits out the synchronizer before each status read. A table of control-register values is written in loopback. It drives every internal-to-status mapping and both RI edge directions without touching the pins. The loopback path from a control write to the change flags is fully synchronous and takes exactly two edges, so a read can be placed on the very edge where a new change lands. That puts the same-cycle read-and-set case within reach.

// File: rtl/modem_pkg.sv
package modem_pkg;

  localparam int DATA_W = 8;

  // control register bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OP1  = 2;
  localparam int CTL_OP2  = 3;
  localparam int CTL_LOOP = 4;
  localparam int CTL_W    = 5;

  // handshake input indices (also status flag positions)
  localparam int HS_CTS = 0;
  localparam int HS_DSR = 1;
  localparam int HS_RI  = 2;
  localparam int HS_CD  = 3;
  localparam int HS_W   = 4;

  typedef struct packed {
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } ctl_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {DEPTH{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < DEPTH; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[DEPTH-1];

endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import modem_pkg::*;
#(
  parameter int                ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  wr_bits,
  input  logic              core_txd,
  input  logic              rxd,
  output ctl_t              ctl_q,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              aux_n,
  output logic              txd,
  output logic              core_rxd
);

  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && addr == CTRL_ADDR) begin
      ctl_d = ctl_t'(wr_bits);
    end
  end

  // pins driven from the next register value so they move with the write
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      rts_n    <= 1'b1;
      dtr_n    <= 1'b1;
      aux_n    <= 1'b1;
      txd      <= 1'b1;
      core_rxd <= 1'b1;
    end else begin
      ctl_q    <= ctl_d;
      rts_n    <= ctl_d.loop | ~ctl_d.rts;
      dtr_n    <= ctl_d.loop | ~ctl_d.dtr;
      aux_n    <= ctl_d.loop | ~ctl_d.op2;
      txd      <= ctl_q.loop | core_txd;
      core_rxd <= ctl_q.loop ? core_txd : rxd;
    end
  end

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import modem_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [HS_W-1:0] pin_sync_n,
  input  ctl_t            ctl_q,
  input  logic            rd_stat,
  output logic [HS_W-1:0] lvl_q,
  output logic [HS_W-1:0] delta_q,
  output logic            irq
);

  logic [HS_W-1:0] src;
  logic [HS_W-1:0] hit;
  logic [HS_W-1:0] delta_n;

  // loopback substitutes the control bits for the external lines
  always_comb begin
    if (ctl_q.loop) begin
      src[HS_CTS] = ctl_q.rts;
      src[HS_DSR] = ctl_q.dtr;
      src[HS_RI]  = ctl_q.op1;
      src[HS_CD]  = ctl_q.op2;
    end else begin
      src = ~pin_sync_n;
    end
  end

  genvar b;
  generate
    for (b = 0; b < HS_W; b++) begin : g_edge
      if (b == HS_RI) begin : g_trail
        assign hit[b] = lvl_q[b] & ~src[b];
      end else begin : g_any
        assign hit[b] = lvl_q[b] ^ src[b];
      end
    end
  endgenerate

  assign delta_n = (rd_stat ? '0 : delta_q) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      delta_q <= '0;
      irq     <= 1'b0;
    end else begin
      lvl_q   <= src;
      delta_q <= delta_n;
      irq     <= |delta_n;
    end
  end

endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
  import modem_pkg::*;
#(
  parameter int                ADDR_W      = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'(6),
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              aux_n,
  input  logic              core_txd,
  output logic              core_rxd,
  input  logic              rxd,
  output logic              txd,
  output logic              msi_irq
);

  localparam int PAD_W = DATA_W - CTL_W;

  ctl_t            ctl_q;
  logic [HS_W-1:0] pins_n;
  logic [HS_W-1:0] pins_sync_n;
  logic [HS_W-1:0] lvl_q;
  logic [HS_W-1:0] delta_q;
  logic            rd_stat;
  logic            loop_on;
  logic            wr_unused;

  assign wr_unused = ^wr_data[DATA_W-1:CTL_W];
  assign pins_n    = {cd_n, ri_n, dsr_n, cts_n};
  assign rd_stat   = rd_en && addr == STAT_ADDR;
  assign loop_on   = ctl_q.loop;

  mdm_sync #(
    .WIDTH  (HS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pins_n),
    .q  (pins_sync_n)
  );

  mdm_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_bits (wr_data[CTL_W-1:0]),
    .core_txd(core_txd),
    .rxd     (rxd),
    .ctl_q   (ctl_q),
    .rts_n   (rts_n),
    .dtr_n   (dtr_n),
    .aux_n   (aux_n),
    .txd     (txd),
    .core_rxd(core_rxd)
  );

  mdm_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .pin_sync_n(pins_sync_n),
    .ctl_q     (ctl_q),
    .rd_stat   (rd_stat),
    .lvl_q     (lvl_q),
    .delta_q   (delta_q),
    .irq       (msi_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (addr == CTRL_ADDR)      rd_data <= {{PAD_W{1'b0}}, ctl_q};
      else if (addr == STAT_ADDR) rd_data <= {lvl_q, delta_q};
      else                        rd_data <= '0;
    end
  end

endmodule

// File: rtl/modem_ctl_loop_chk.sv
module mdm_checker #(
  parameter int                ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(6)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              loop_on,
  input logic [3:0]        lvl_q,
  input logic              rts_n,
  input logic              dtr_n,
  input logic              aux_n,
  input logic              txd,
  input logic              core_txd,
  input logic              core_rxd,
  input logic              msi_irq
);

  p_pin_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR && !wr_data[4]) |=>
      (rts_n == !$past(wr_data[1])) && (dtr_n == !$past(wr_data[0]))
      && (aux_n == !$past(wr_data[3])));

  p_loop_pins_idle_r8: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> (rts_n && dtr_n && aux_n));

  p_tx_idle_r6: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> txd);

  p_rx_loop_r7: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> (core_rxd == $past(core_txd)));

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (msi_irq && !(rd_en && addr == STAT_ADDR)) |=> msi_irq);

  p_irq_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(msi_irq) |-> (lvl_q != $past(lvl_q)));

endmodule

bind modem_ctl_loop mdm_checker #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .loop_on (loop_on),
  .lvl_q   (lvl_q),
  .rts_n   (rts_n),
  .dtr_n   (dtr_n),
  .aux_n   (aux_n),
  .txd     (txd),
  .core_txd(core_txd),
  .core_rxd(core_rxd),
  .msi_irq (msi_irq)
);

// File: tb/sim_modem_ctl_loop.sv
module sim_modem_ctl_loop;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int         AW   = 3;
  localparam logic [2:0] CTRL = 3'd4;
  localparam logic [2:0] STAT = 3'd6;

  // {control byte written in loopback, expected status read afterwards}
  localparam logic [15:0] VEC [8] = '{
    16'h1333, 16'h1770, 16'h1334, 16'h1BB8,
    16'h100B, 16'h1440, 16'h1004, 16'h1211
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic          rts_n, dtr_n, aux_n;
  logic          core_txd = 1'b1, rxd = 1'b1;
  logic          core_rxd, txd, msi_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] got;

  always #10 clk = ~clk;

  modem_ctl_loop #(
    .ADDR_W(AW), .CTRL_ADDR(CTRL), .STAT_ADDR(STAT), .SYNC_STAGES(3)
  ) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .aux_n(aux_n),
    .core_txd(core_txd), .core_rxd(core_rxd), .rxd(rxd), .txd(txd),
    .msi_irq(msi_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R9 reset state
    check("R9 pins", {4'h0, rts_n, dtr_n, aux_n, txd}, 8'h0F);
    check("R9 irq", {7'h0, msi_irq}, 8'h00);
    check("R9 rd_data", rd_data, 8'h00);
    rst = 1'b0;
    idle(5);
    rd(CTRL, got); check("R9 ctrl reg", got, 8'h00);
    rd(STAT, got); check("R9 status", got, 8'h00);

    // R5 pin drive
    wr(CTRL, 8'h02);
    check("R5 rts only", {5'h0, rts_n, dtr_n, aux_n}, 8'h03);
    wr(CTRL, 8'h09);
    check("R5 dtr aux", {5'h0, rts_n, dtr_n, aux_n}, 8'h04);
    rd(CTRL, got); check("R5 readback", got, 8'h09);

    // R6 / R7 normal paths
    core_txd = 1'b0; idle(2);
    check("R6 txd follows", {7'h0, txd}, 8'h00);
    core_txd = 1'b1; rxd = 1'b0; idle(2);
    check("R7 rxd pass", {7'h0, core_rxd}, 8'h00);
    rxd = 1'b1; idle(2);

    // R1 external changes
    cts_n = 1'b0; idle(8);
    check("R4 irq set", {7'h0, msi_irq}, 8'h01);
    rd(STAT, got); check("R1 cts change", got, 8'h11);
    check("R4 irq cleared", {7'h0, msi_irq}, 8'h00);
    cd_n = 1'b0; idle(8);
    rd(STAT, got); check("R1 cd change", got, 8'h98);
    cts_n = 1'b1; cd_n = 1'b1; dsr_n = 1'b0; idle(8);
    rd(STAT, got); check("R1 falling and dsr", got, 8'h2B);
    dsr_n = 1'b1; idle(8);
    rd(STAT, got); check("R1 dsr release", got, 8'h02);

    // R2 ring indicator edges
    ri_n = 1'b0; idle(8);
    check("R2 no irq on leading", {7'h0, msi_irq}, 8'h00);
    rd(STAT, got); check("R2 leading", got, 8'h40);
    ri_n = 1'b1; idle(8);
    rd(STAT, got); check("R2 trailing", got, 8'h04);

    // R8 loopback table
    wr(CTRL, 8'h10); idle(3);
    rd(STAT, got); rd(STAT, got);
    check("R8 loop clear", got, 8'h00);
    for (int i = 0; i < 8; i++) begin
      wr(CTRL, VEC[i][15:8]); idle(3);
      rd(STAT, got);
      check($sformatf("R8 vec%0d", i), got, VEC[i][7:0]);
      check($sformatf("R4 vec%0d irq", i), {7'h0, msi_irq}, 8'h00);
    end

    // R8 external pins ignored in loopback
    cts_n = 1'b0; dsr_n = 1'b0; ri_n = 1'b0; cd_n = 1'b0; idle(8);
    check("R8 ext ignored irq", {7'h0, msi_irq}, 8'h00);
    rd(STAT, got); check("R8 ext ignored status", got, 8'h10);
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; cd_n = 1'b1; idle(8);
    wr(CTRL, 8'h1B);
    check("R8 pins parked", {5'h0, rts_n, dtr_n, aux_n}, 8'h07);

    // R6 / R7 in loopback
    core_txd = 1'b0; rxd = 1'b1; idle(2);
    check("R6 txd idle in loop", {7'h0, txd}, 8'h01);
    check("R7 looped zero", {7'h0, core_rxd}, 8'h00);
    core_txd = 1'b1; rxd = 1'b0; idle(2);
    check("R7 looped one", {7'h0, core_rxd}, 8'h01);
    rxd = 1'b1;

    // R3 change landing on the read edge
    wr(CTRL, 8'h10); idle(3);
    rd(STAT, got); rd(STAT, got);
    wr(CTRL, 8'h12);
    rd(STAT, got); check("R3 read before change", got, 8'h00);
    check("R3 flag kept irq", {7'h0, msi_irq}, 8'h01);
    rd(STAT, got); check("R3 flag kept", got, 8'h11);

    // leave loopback
    wr(CTRL, 8'h00); idle(3);
    rd(STAT, got);
    core_txd = 1'b0; idle(2);
    check("R6 txd restored", {7'h0, txd}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule